// File: doc/BRIEF.md
# Oversampling Nine-Bit Serial Receiver

This block receives asynchronous serial frames of eleven bit periods each: a low start bit, eight data bits sent least significant bit first, a ninth data bit and a stop bit. The line is sampled on an internal oversampling tick that runs at sixteen ticks per bit. The tick is derived from the system clock through one of two divisors, chosen by a rate-select input. A 1-to-0 transition seen on a tick, while the receiver is idle and enabled, starts a frame and restarts the bit-phase counter. Each bit is then decided by a two-of-three majority of the samples taken at phase counts 8, 9 and 10.

If the start bit is decided as 1, the receiver treats the edge as noise and goes back to hunting for an edge. After the start bit, nine bits are shifted in. The stop bit is decided last, and only then are the data and ninth-bit registers loaded and the done flag raised. The load also requires that the done flag is clear, and, when the address-filter mode input is high, that the stop bit was 1. A frame that fails these conditions is dropped without a trace. The done flag stays set until a clear strobe arrives.

Top module: `uart9_rx`

## Requirements
- R1: After reset, rxDone is 0, rxData is 0x00 and rxBit9 is 0.
- R2: A frame with start bit 0, data bits d0..d7 (d0 first), ninth bit b9 and stop bit 1 loads rxData = {d7..d0} and rxBit9 = b9, and sets rxDone once the stop bit is decided.
- R3: With fastRate = 1 a bit lasts 16*DIV_FAST clock cycles; with fastRate = 0 it lasts 16*DIV_SLOW clock cycles. Frames sent at the matching rate are received correctly.
- R4: While rxEnable is 0 no frame is started or loaded. Dropping rxEnable during a frame abandons that frame.
- R5: Each bit is the majority of the samples taken at phase counts 8, 9 and 10 after the frame's falling edge. A disturbance that inverts a single oversampling tick inside a bit does not change the received value.
- R6: If the start bit is decided as 1, the frame is abandoned and the receiver hunts for a new falling edge. A following valid frame is received normally.
- R7: If rxDone is 1 when the stop bit is decided, the frame is discarded: rxData and rxBit9 keep their values and rxDone stays 1.
- R8: With addrFilter = 1, a frame whose stop bit is decided as 0 is discarded and one with stop bit 1 is loaded. With addrFilter = 0, the stop bit value does not gate the load.
- R9: clearDone drives rxDone to 0 on the next clock. If a load falls in the same cycle as clearDone, the load wins and rxDone is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fastRate | input | 1 | 1 selects divisor DIV_FAST, 0 selects DIV_SLOW for the oversampling tick |
| rxEnable | input | 1 | Reception allowed while high |
| addrFilter | input | 1 | When high, a stop bit of 0 blocks the load |
| rxLine | input | 1 | Serial input line, idles high |
| clearDone | input | 1 | Strobe that clears the done flag |
| rxData | output | 8 | Last accepted data byte |
| rxBit9 | output | 1 | Ninth bit of the last accepted frame |
| rxDone | output | 1 | Frame-received flag |

## Verification
The clear strobe and the frame load can land on the same clock edge, and the rule says the load wins. The bench holds clearDone high for the whole stop-bit period of a frame, so the load cycle is covered without the bench predicting that exact edge. It then checks that rxDone was seen high at least once in that window, that the byte arrived intact, and that the flag reads 0 once the strobe is released.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RECV = 1'b1
  } rxState_t;

  typedef struct packed {
    logic takeFirst;
    logic takeSecond;
    logic shiftIn;
    logic loadOut;
  } rxStrobe_t;
endpackage

// File: rtl/uart9_tick.sv
module uart9_tick #(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic fastRate,
  output logic tick
);
  localparam int MAXDIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

  logic [CW-1:0] divCount;
  logic [CW-1:0] divLast;

  always_comb begin
    divLast = fastRate ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
    tick = (divCount >= divLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCount <= '0;
    else if (tick) divCount <= '0;
    else divCount <= divCount + 1'b1;
  end
endmodule

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
  import uart9_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxEnable,
  input  logic      addrFilter,
  input  logic      fallEdge,
  input  logic      voteBit,
  input  logic      doneFlag,
  output rxStrobe_t strobe
);
  localparam int PW = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2;
  localparam int STOP_IDX = DATA_BITS + 1;
  localparam int IW = $clog2(STOP_IDX + 1);

  rxState_t state;
  logic [PW-1:0] phase;
  logic [IW-1:0] bitIdx;
  logic decide;

  always_comb begin
    decide = (state == ST_RECV) && rxEnable && tick && (phase == PW'(MID + 2));
    strobe.takeFirst  = (state == ST_RECV) && tick && (phase == PW'(MID));
    strobe.takeSecond = (state == ST_RECV) && tick && (phase == PW'(MID + 1));
    strobe.shiftIn    = decide && (bitIdx != '0) && (bitIdx != IW'(STOP_IDX));
    strobe.loadOut    = decide && (bitIdx == IW'(STOP_IDX)) && !doneFlag &&
                        (!addrFilter || voteBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      phase  <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (rxEnable && tick && fallEdge) begin
            state  <= ST_RECV;
            phase  <= '0;
            bitIdx <= '0;
          end
        end
        default: begin
          if (!rxEnable) begin
            state <= ST_HUNT;
          end else if (tick) begin
            phase <= phase + 1'b1;
            if (decide) begin
              if (bitIdx == '0 && voteBit) state <= ST_HUNT;
              else if (bitIdx == IW'(STOP_IDX)) state <= ST_HUNT;
              else bitIdx <= bitIdx + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_false_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (decide && bitIdx == '0 && voteBit) |=> (state == ST_HUNT));

  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable) |=> (state == ST_HUNT));
endmodule

// File: rtl/uart9_dpath.sv
module uart9_dpath
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              rxLine,
  input  logic              clearDone,
  input  rxStrobe_t         strobe,
  output logic              fallEdge,
  output logic              voteBit,
  output logic              doneFlag,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9
);
  localparam int SW = DATA_W + 1;

  logic syncA, syncB, lastSamp;
  logic sampA, sampB;
  logic [SW-1:0] shiftReg;

  always_comb begin
    fallEdge = lastSamp && !syncB;
    voteBit  = (sampA & sampB) | (sampA & syncB) | (sampB & syncB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      lastSamp <= 1'b1;
      sampA    <= 1'b1;
      sampB    <= 1'b1;
      shiftReg <= '0;
    end else begin
      syncA <= rxLine;
      syncB <= syncA;
      if (tick) lastSamp <= syncB;
      if (strobe.takeFirst) sampA <= syncB;
      if (strobe.takeSecond) sampB <= syncB;
      if (strobe.shiftIn) shiftReg <= {voteBit, shiftReg[SW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxBit9   <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (strobe.loadOut) begin
        rxData   <= shiftReg[DATA_W-1:0];
        rxBit9   <= shiftReg[SW-1];
        doneFlag <= 1'b1;
      end else if (clearDone) begin
        doneFlag <= 1'b0;
      end
    end
  end

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clearDone && !strobe.loadOut) |=> !doneFlag);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !clearDone) |=> (doneFlag && $stable(rxData) && $stable(rxBit9)));

  assert_load_free_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |-> !doneFlag);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DIV_SLOW   = 4,
  parameter int DIV_FAST   = 2,
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastRate,
  input  logic              rxEnable,
  input  logic              addrFilter,
  input  logic              rxLine,
  input  logic              clearDone,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone
);
  localparam int DATA_BITS = DATA_W + 1;

  logic tick, fallEdge, voteBit;
  rxStrobe_t strobe;

  uart9_tick #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) uTick (
    .clk(clk), .rstN(rstN), .fastRate(fastRate), .tick(tick)
  );

  uart9_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxEnable(rxEnable),
    .addrFilter(addrFilter), .fallEdge(fallEdge), .voteBit(voteBit),
    .doneFlag(rxDone), .strobe(strobe)
  );

  uart9_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine),
    .clearDone(clearDone), .strobe(strobe), .fallEdge(fallEdge),
    .voteBit(voteBit), .doneFlag(rxDone), .rxData(rxData), .rxBit9(rxBit9)
  );
endmodule

// File: tb/uart9_rx_test.sv
module uart9_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_SLOW = 4;
  localparam int DIV_FAST = 2;

  logic clk = 0, rstN = 0, fastRate = 1, rxEnable = 0, addrFilter = 0;
  logic rxLine = 1, clearDone = 0;
  logic [7:0] rxData;
  logic rxBit9, rxDone;
  int checks = 0, fails = 0;
  bit seenDone;

  uart9_rx uut (
    .clk(clk), .rstN(rstN), .fastRate(fastRate), .rxEnable(rxEnable),
    .addrFilter(addrFilter), .rxLine(rxLine), .clearDone(clearDone),
    .rxData(rxData), .rxBit9(rxBit9), .rxDone(rxDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  function automatic int bitClocks();
    return 16 * (fastRate ? DIV_FAST : DIV_SLOW);
  endfunction

  // glitchBit: index in frame (0 start .. 10 stop) to disturb for one tick, -1 none
  task automatic sendFrame(input logic [7:0] d, input logic b9, input logic stopV,
                           input int glitchBit, input bit holdClearOnStop);
    logic [10:0] f;
    int bc;
    f = {stopV, b9, d, 1'b0};
    bc = bitClocks();
    for (int i = 0; i < 11; i++) begin
      for (int c = 0; c < bc; c++) begin
        @(negedge clk);
        if (i == 10 && holdClearOnStop) begin
          clearDone = 1;
          if (rxDone) seenDone = 1;
        end
        if (i == glitchBit && c >= 9 * (bc/16) && c < 10 * (bc/16)) rxLine = ~f[i];
        else rxLine = f[i];
      end
    end
    @(negedge clk);
    if (holdClearOnStop && rxDone) seenDone = 1;
    rxLine = 1;
    clearDone = 0;
    repeat (2 * bc) @(negedge clk);
  endtask

  task automatic doClear();
    @(negedge clk); clearDone = 1;
    @(negedge clk); clearDone = 0;
  endtask

  task automatic testReset();
    check("R1 rxDone", rxDone, 0);
    check("R1 rxData", rxData, 0);
    check("R1 rxBit9", rxBit9, 0);
  endtask

  task automatic testBasic();
    fastRate = 1;
    sendFrame(8'hA5, 1'b1, 1'b1, -1, 0);
    check("R2 R3 fast rxData", rxData, 8'hA5);
    check("R2 rxBit9", rxBit9, 1);
    check("R2 rxDone", rxDone, 1);
    doClear();
    @(negedge clk);
    check("R9 clear", rxDone, 0);
  endtask

  task automatic testSlow();
    fastRate = 0;
    repeat (8) @(negedge clk);
    sendFrame(8'h3C, 1'b0, 1'b1, -1, 0);
    check("R3 slow rxData", rxData, 8'h3C);
    check("R3 slow rxBit9", rxBit9, 0);
    check("R3 slow rxDone", rxDone, 1);
    doClear();
    fastRate = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic testDisabled();
    rxEnable = 0;
    sendFrame(8'h11, 1'b0, 1'b1, -1, 0);
    check("R4 disabled rxDone", rxDone, 0);
    check("R4 disabled rxData", rxData, 8'h3C);
    rxEnable = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic testFalseStart();
    @(negedge clk); rxLine = 0;
    repeat (4 * DIV_FAST) @(negedge clk);
    rxLine = 1;
    repeat (40 * 16 * DIV_FAST) @(negedge clk);
    check("R6 false start no done", rxDone, 0);
    sendFrame(8'h5A, 1'b1, 1'b1, -1, 0);
    check("R6 after false start rxData", rxData, 8'h5A);
    check("R6 after false start rxDone", rxDone, 1);
    doClear();
  endtask

  task automatic testGlitch();
    // bit index 2 carries d1 = 1 in 0xF3; bit index 3 carries d2 = 0
    sendFrame(8'hF3, 1'b0, 1'b1, 2, 0);
    check("R5 glitch on 1 bit rxData", rxData, 8'hF3);
    doClear();
    sendFrame(8'hF3, 1'b1, 1'b1, 3, 0);
    check("R5 glitch on 0 bit rxData", rxData, 8'hF3);
    check("R5 glitch rxBit9", rxBit9, 1);
    doClear();
  endtask

  task automatic testDoneBlocks();
    sendFrame(8'h77, 1'b0, 1'b1, -1, 0);
    sendFrame(8'h88, 1'b1, 1'b1, -1, 0);
    check("R7 discarded rxData", rxData, 8'h77);
    check("R7 discarded rxBit9", rxBit9, 0);
    check("R7 rxDone held", rxDone, 1);
    doClear();
  endtask

  task automatic testFilter();
    addrFilter = 1;
    sendFrame(8'h42, 1'b1, 1'b0, -1, 0);
    check("R8 bad stop filtered", rxDone, 0);
    check("R8 bad stop rxData", rxData, 8'h77);
    sendFrame(8'h43, 1'b1, 1'b1, -1, 0);
    check("R8 good stop loaded", rxData, 8'h43);
    check("R8 good stop rxDone", rxDone, 1);
    doClear();
    addrFilter = 0;
    sendFrame(8'h44, 1'b0, 1'b0, -1, 0);
    check("R8 no filter bad stop loaded", rxData, 8'h44);
    doClear();
  endtask

  task automatic testClearCollide();
    seenDone = 0;
    sendFrame(8'hC9, 1'b1, 1'b1, -1, 1);
    check("R9 load beats clear", int'(seenDone), 1);
    check("R9 collide rxData", rxData, 8'hC9);
    check("R9 cleared after", rxDone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    rxEnable = 1;
    repeat (40) @(negedge clk);
    testBasic();
    testSlow();
    testDisabled();
    testFalseStart();
    testGlitch();
    testDoneBlocks();
    testFilter();
    testClearCollide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule